// File: doc/BRIEF.md
# SPI ADC Command Sequencer

This block is an SPI master that lets on-chip logic drive a multichannel successive-approximation ADC. A client presents an operation code together with a register address, a data byte or a channel number, and pulses a start strobe. The sequencer then builds the serial frames, generates the serial clock at a fixed fraction of the system clock, frames each transfer with an active-low chip select, shifts command bits out and samples returned bits. While a command is in progress it holds a busy flag. When a command produces data it pulses a valid strobe.

Three operations exist. A register write sends one 24-bit frame. A register read needs two frames. The first frame carries the read command, and the register value comes back in the first byte of the second frame. A conversion captures a 12-bit sample. Its frame depends on the converter mode. While on-the-fly channel selection is off, the conversion frame is 24 zero bits. After a write to the mode register turns on-the-fly selection on, the conversion frame becomes 16 bits long and carries the channel number in its leading bits. A read result that is all zeros or all ones is flagged as a likely link fault.

The controller has five states. S_IDLE waits for a start strobe. S_WRITE, S_RD_ISSUE and S_CONVERT each run a single frame. S_RD_FETCH runs the second frame of a read. The transitions are:
- S_IDLE goes to S_WRITE, S_RD_ISSUE or S_CONVERT on an accepted start.
- S_RD_ISSUE goes to S_RD_FETCH when its frame completes.
- S_WRITE, S_RD_FETCH and S_CONVERT return to S_IDLE when their frame completes.

The frame engine has its own states:
- E_IDLE: chip select high.
- E_LEAD: clock low.
- E_HIGH: clock high.
- E_TAIL: final low half-period with chip select still low.
- E_GAP: chip select high for the separation time.

Top module: `spi_adc_seq`

## Requirements
- R1: `sclk` stays low whenever `cs_n` is high. Inside a frame it has a period of CLK_DIV system clocks (4 by default), with a high time of CLK_DIV/2. The first half-period after `cs_n` falls is low (mode 0).
- R2: Op code 0 (write) sends exactly one frame of 24 clocks. The bits are 0x08, then `cmd_addr`, then `cmd_data`, most significant bit first, sampled by the device on the rising edge of `sclk`. No valid strobe follows.
- R3: Op code 1 (read) sends two 24-clock frames. The first is 0x10, then the address, then 0x00. The second is all zero bits. `rslt_data` becomes the first 8 bits sampled on `miso` during the second frame, zero-extended to 12 bits.
- R4: Between any two frames `cs_n` stays high for at least CLK_DIV system clocks.
- R5: A completed write to address 0x10 sets `otf_active` to bit 1 of the written data. Writes to other addresses and all other operations leave `otf_active` unchanged. It is 0 after reset.
- R6: Op code 2 (conversion) with `otf_active` = 1 sends one 16-clock frame. Frame bits 15:14 are 2'b10, bits 13:10 are `cmd_chan`, and bits 9:0 are zero. `rslt_data` is the first 12 bits sampled on `miso`, first bit as bit 11.
- R7: Op code 2 with `otf_active` = 0 sends one 24-clock frame of zero bits. `rslt_data` is the first 12 bits sampled on `miso`.
- R8: `busy` rises on the cycle after an accepted start and falls when the last frame ends. For reads and conversions, `rslt_valid` is high for exactly one cycle, on the first cycle in which `busy` is low. `cs_n` is never low while `busy` is low.
- R9: A start strobe while `busy` is high is ignored. A start with op code 3 is ignored. Neither produces a frame, changes `otf_active` or raises `busy`.
- R10: Along with a read result, `rslt_fault` is 1 when the byte is 0x00 or 0xFF and 0 otherwise, so 0x80 and 0x81 give 0. A conversion result always gives `rslt_fault` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strobe for one command |
| cmd_op | input | 2 | 0 write, 1 read, 2 conversion, 3 no operation |
| cmd_addr | input | 8 | Register address |
| cmd_data | input | 8 | Register write data |
| cmd_chan | input | CH_W | Channel for on-the-fly conversions |
| busy | output | 1 | Command in progress |
| rslt_valid | output | 1 | One-cycle result strobe |
| rslt_data | output | RES_W | Read byte (zero-extended) or conversion sample |
| rslt_fault | output | 1 | Read byte was all zeros or all ones |
| otf_active | output | 1 | On-the-fly channel selection is in force |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
The hardest case to reach from the ports is the hand-off inside a register read. The sequencer must let `cs_n` go high, then start a second frame whose response, and not the first frame's, becomes the result. At that moment a stray start strobe must not be taken. The bench slave answers each frame of a command with a different word, so a result taken from the wrong frame shows up. A write to the mode register is issued while a read is in flight, so an accepted stray start would show up as a third frame and a changed mode flag. Random command mixes aim writes at the mode address often enough to cross the 16-bit and 24-bit conversion formats many times.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_CONV  = 2'd2,
        OP_NONE  = 2'd3
    } cmd_op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_RD_ISSUE,
        S_RD_FETCH,
        S_CONVERT
    } seq_state_t;

    typedef enum logic [2:0] {
        E_IDLE,
        E_LEAD,
        E_HIGH,
        E_TAIL,
        E_GAP
    } eng_state_t;

    typedef enum logic [1:0] {
        FK_WRITE,
        FK_RD_ISSUE,
        FK_RD_FETCH,
        FK_CONV
    } frame_kind_t;

    localparam int unsigned WORD_BITS  = 24;
    localparam int unsigned OTF_BITS   = 16;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned OTF_EN_BIT = 1;

    localparam logic [7:0] OPC_REG_WR = 8'h08;
    localparam logic [7:0] OPC_REG_RD = 8'h10;
    localparam logic [7:0] MODE_REG   = 8'h10;

endpackage

// File: rtl/spi_adc_frame_build.sv
module spi_adc_frame_build
    import spi_adc_pkg::*;
#(
    parameter int unsigned CH_W  = 4,
    parameter int unsigned LEN_W = 5
) (
    input  frame_kind_t               kind,
    input  logic                      otf,
    input  logic [BYTE_W-1:0]         addr,
    input  logic [BYTE_W-1:0]         data,
    input  logic [CH_W-1:0]           chan,
    output logic [WORD_BITS-1:0]      tx_word,
    output logic [LEN_W-1:0]          bit_len
);

    localparam int unsigned PAD_W = WORD_BITS - 2 - CH_W;

    always_comb begin
        tx_word = '0;
        bit_len = LEN_W'(WORD_BITS);
        unique case (kind)
            FK_WRITE:    tx_word = {OPC_REG_WR, addr, data};
            FK_RD_ISSUE: tx_word = {OPC_REG_RD, addr, {BYTE_W{1'b0}}};
            FK_RD_FETCH: tx_word = '0;
            FK_CONV: begin
                if (otf) begin
                    tx_word = {2'b10, chan, {PAD_W{1'b0}}};
                    bit_len = LEN_W'(OTF_BITS);
                end
            end
            default: tx_word = '0;
        endcase
    end

endmodule

// File: rtl/spi_adc_frame_engine.sv
module spi_adc_frame_engine
    import spi_adc_pkg::*;
#(
    parameter int unsigned CLK_DIV  = 4,
    parameter int unsigned MAX_BITS = 24,
    parameter int unsigned LEN_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [MAX_BITS-1:0]  tx_word,
    input  logic [LEN_W-1:0]     bit_len,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    output logic                 done,
    output logic [MAX_BITS-1:0]  rx_word
);

    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam int unsigned CNT_W = $clog2(CLK_DIV) + 1;

    eng_state_t           state, nxt;
    logic [CNT_W-1:0]     cnt;
    logic [LEN_W-1:0]     left;
    logic [MAX_BITS-1:0]  tx_sr;
    logic [MAX_BITS-1:0]  rx_sr;
    logic                 phase_end;

    assign phase_end = (state == E_GAP) ? (cnt == CNT_W'(CLK_DIV - 1))
                                        : (cnt == CNT_W'(HALF - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            E_IDLE: if (go)        nxt = E_LEAD;
            E_LEAD: if (phase_end) nxt = E_HIGH;
            E_HIGH: if (phase_end) nxt = (left == LEN_W'(1)) ? E_TAIL : E_LEAD;
            E_TAIL: if (phase_end) nxt = E_GAP;
            E_GAP:  if (phase_end) nxt = E_IDLE;
            default:               nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= E_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state != nxt || state == E_IDLE) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            left  <= '0;
        end else begin
            if (state == E_IDLE && go) begin
                tx_sr <= tx_word;
                left  <= bit_len;
                rx_sr <= '0;
            end
            if (state == E_LEAD && phase_end) begin
                rx_sr <= {rx_sr[MAX_BITS-2:0], miso};
            end
            if (state == E_HIGH && phase_end && left != LEN_W'(1)) begin
                tx_sr <= {tx_sr[MAX_BITS-2:0], 1'b0};
                left  <= left - 1'b1;
            end
        end
    end

    assign sclk    = (state == E_HIGH);
    assign cs_n    = (state == E_IDLE) || (state == E_GAP);
    assign mosi    = !cs_n && tx_sr[MAX_BITS-1];
    assign done    = (state == E_GAP) && phase_end;
    assign rx_word = rx_sr;

endmodule

// File: rtl/spi_adc_seq.sv
module spi_adc_seq
    import spi_adc_pkg::*;
#(
    parameter int unsigned CLK_DIV = 4,
    parameter int unsigned CH_W    = 4,
    parameter int unsigned RES_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [7:0]        cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [CH_W-1:0]   cmd_chan,
    output logic              busy,
    output logic              rslt_valid,
    output logic [RES_W-1:0]  rslt_data,
    output logic              rslt_fault,
    output logic              otf_active,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);

    localparam int unsigned LEN_W = $clog2(WORD_BITS + 1);

    seq_state_t             state, nxt;
    cmd_op_t                op_in;
    logic                   accept;
    logic [BYTE_W-1:0]      addr_q, data_q;
    logic [CH_W-1:0]        chan_q;
    logic                   otf_q;
    logic                   eng_go;
    frame_kind_t            kind_q;
    logic [WORD_BITS-1:0]   eng_tx;
    logic [LEN_W-1:0]       eng_len;
    logic                   eng_done;
    logic [WORD_BITS-1:0]   eng_rx;
    logic [BYTE_W-1:0]      rd_byte;

    assign op_in   = cmd_op_t'(cmd_op);
    assign accept  = (state == S_IDLE) && cmd_start && (op_in != OP_NONE);
    assign rd_byte = eng_rx[WORD_BITS-1 -: BYTE_W];

    spi_adc_frame_build #(
        .CH_W  (CH_W),
        .LEN_W (LEN_W)
    ) u_build (
        .kind    (kind_q),
        .otf     (otf_q),
        .addr    (addr_q),
        .data    (data_q),
        .chan    (chan_q),
        .tx_word (eng_tx),
        .bit_len (eng_len)
    );

    spi_adc_frame_engine #(
        .CLK_DIV  (CLK_DIV),
        .MAX_BITS (WORD_BITS),
        .LEN_W    (LEN_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eng_go),
        .tx_word (eng_tx),
        .bit_len (eng_len),
        .miso    (miso),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .done    (eng_done),
        .rx_word (eng_rx)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    unique case (op_in)
                        OP_WRITE: nxt = S_WRITE;
                        OP_READ:  nxt = S_RD_ISSUE;
                        default:  nxt = S_CONVERT;
                    endcase
                end
            end
            S_WRITE:    if (eng_done) nxt = S_IDLE;
            S_RD_ISSUE: if (eng_done) nxt = S_RD_FETCH;
            S_RD_FETCH: if (eng_done) nxt = S_IDLE;
            S_CONVERT:  if (eng_done) nxt = S_IDLE;
            default:                  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            data_q     <= '0;
            chan_q     <= '0;
            otf_q      <= 1'b0;
            eng_go     <= 1'b0;
            kind_q     <= FK_WRITE;
            rslt_valid <= 1'b0;
            rslt_data  <= '0;
            rslt_fault <= 1'b0;
        end else begin
            eng_go     <= 1'b0;
            rslt_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        addr_q <= cmd_addr;
                        data_q <= cmd_data;
                        chan_q <= cmd_chan;
                        eng_go <= 1'b1;
                        unique case (op_in)
                            OP_WRITE: kind_q <= FK_WRITE;
                            OP_READ:  kind_q <= FK_RD_ISSUE;
                            default:  kind_q <= FK_CONV;
                        endcase
                    end
                end
                S_WRITE: begin
                    if (eng_done && addr_q == MODE_REG) otf_q <= data_q[OTF_EN_BIT];
                end
                S_RD_ISSUE: begin
                    if (eng_done) begin
                        eng_go <= 1'b1;
                        kind_q <= FK_RD_FETCH;
                    end
                end
                S_RD_FETCH: begin
                    if (eng_done) begin
                        rslt_valid <= 1'b1;
                        rslt_data  <= {{(RES_W-BYTE_W){1'b0}}, rd_byte};
                        rslt_fault <= (rd_byte == '0) || (rd_byte == '1);
                    end
                end
                S_CONVERT: begin
                    if (eng_done) begin
                        rslt_valid <= 1'b1;
                        rslt_fault <= 1'b0;
                        rslt_data  <= otf_q ? eng_rx[OTF_BITS-1 -: RES_W]
                                            : eng_rx[WORD_BITS-1 -: RES_W];
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = (state != S_IDLE);
    assign otf_active = otf_q;

endmodule

// File: rtl/spi_adc_seq_chk.sv
module spi_adc_seq_chk #(
    parameter int unsigned CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic busy,
    input logic rslt_valid,
    input logic otf_active
);

    localparam int unsigned GW = $clog2(CLK_DIV + 1) + 1;

    logic [GW-1:0] gap_cnt;
    logic          seen_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt    <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (!cs_n) seen_frame <= 1'b1;
            if (!cs_n)                         gap_cnt <= '0;
            else if (gap_cnt < GW'(CLK_DIV))   gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R1

    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && seen_frame) |-> (gap_cnt >= GW'(CLK_DIV))); // R4

    AST_OTF_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(otf_active)); // R5

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |=> !rslt_valid); // R8

    AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |-> !busy); // R8

    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy); // R8

endmodule

bind spi_adc_seq spi_adc_seq_chk #(.CLK_DIV(CLK_DIV)) u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .busy       (busy),
    .rslt_valid (rslt_valid),
    .otf_active (otf_active)
);

// File: tb/test_spi_adc_seq.sv
module test_spi_adc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_addr = 8'd0;
    logic [7:0]  cmd_data = 8'd0;
    logic [3:0]  cmd_chan = 4'd0;
    logic        busy, rslt_valid, rslt_fault, otf_active, sclk, cs_n, mosi;
    logic [11:0] rslt_data;
    logic        miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    spi_adc_seq i_spi_adc_seq (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_chan(cmd_chan),
        .busy(busy), .rslt_valid(rslt_valid), .rslt_data(rslt_data),
        .rslt_fault(rslt_fault), .otf_active(otf_active), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // slave model and link monitors, all evaluated at falling clk edges
    int          cyc = 0, last_rise = 0, bits = 0, cs_hi = 0;
    int          frame_total = 0, base_frame = 0;
    int          sclk_err = 0, gap_err = 0, vcnt = 0, vbusy_err = 0;
    logic        cs_q = 1'b1, sclk_q = 1'b0;
    logic [23:0] sh = '0, acc = '0, resp0 = '0, resp1 = '0;
    int          len_log [256];
    logic [23:0] mosi_log [256];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (rslt_valid) vcnt++;
            if (rslt_valid && busy) vbusy_err++;
            if (cs_n && sclk) sclk_err++;
            if (cs_q && !cs_n) begin
                if (frame_total != 0 && cs_hi < 4) gap_err++;
                sh = (frame_total == base_frame) ? resp0 : resp1;
                miso = sh[23];
                sh = sh << 1;
                bits = 0;
                acc = '0;
            end
            if (!cs_n && sclk && !sclk_q) begin
                if (bits != 0 && (cyc - last_rise) != 4) sclk_err++;
                last_rise = cyc;
                acc = {acc[22:0], mosi};
                bits++;
            end
            if (!cs_n && !sclk && sclk_q) begin
                if ((cyc - last_rise) != 2) sclk_err++;
                miso = sh[23];
                sh = sh << 1;
            end
            if (!cs_q && cs_n) begin
                len_log[frame_total % 256]  = bits;
                mosi_log[frame_total % 256] = acc;
                frame_total++;
            end
            cs_hi = cs_n ? cs_hi + 1 : 0;
        end
        cs_q   = cs_n;
        sclk_q = sclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic byte_fault(input logic [7:0] b);
        return (b == 8'h00) || (b == 8'hFF);
    endfunction

    logic exp_otf = 1'b0;

    task automatic pulse_start(input logic [1:0] op, input logic [7:0] a,
                               input logic [7:0] d, input logic [3:0] ch);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_chan = ch;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_idle(output logic valid_at_idle);
        valid_at_idle = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!busy) begin
                valid_at_idle = rslt_valid;
                return;
            end
        end
        chk("R8 busy timeout", 32'd1, 32'd0);
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                          input logic [3:0] ch, input logic [23:0] r0, input logic [23:0] r1,
                          input logic stray);
        logic v_idle;
        int   nf, v0;
        base_frame = frame_total;
        resp0 = r0; resp1 = r1;
        v0 = vcnt;
        @(negedge clk);
        pulse_start(op, a, d, ch);
        chk("R8 busy after start", busy, 1'b1);
        if (stray) begin
            for (int k = 0; k < 101; k++) @(negedge clk);
            pulse_start(2'd0, 8'h10, ~{6'd0, exp_otf, 1'b0}, 4'd0); // R9 stray start
        end
        wait_idle(v_idle);
        for (int k = 0; k < 12; k++) @(negedge clk);
        nf = frame_total - base_frame;
        unique case (op)
            2'd0: begin
                chk("R2 frame count", nf, 1);
                chk("R2 frame length", len_log[base_frame % 256], 24);
                chk("R2 frame bits", mosi_log[base_frame % 256], {8'h08, a, d});
                chk("R2 no valid", vcnt - v0, 0);
                if (a == 8'h10) exp_otf = d[1];
                chk("R5 mode flag", otf_active, exp_otf);
            end
            2'd1: begin
                chk("R3 frame count", nf, 2);
                chk("R3 cmd frame", mosi_log[base_frame % 256], {8'h10, a, 8'h00});
                chk("R3 fetch frame", mosi_log[(base_frame + 1) % 256], 24'h0);
                chk("R3 lengths", {len_log[base_frame % 256][15:0], len_log[(base_frame + 1) % 256][15:0]},
                    {16'd24, 16'd24});
                chk("R8 valid at busy fall", v_idle, 1'b1);
                chk("R8 single valid", vcnt - v0, 1);
                chk("R3 read data", rslt_data, {4'h0, r1[23:16]});
                chk("R10 fault flag", rslt_fault, byte_fault(r1[23:16]));
                chk("R9 mode unchanged", otf_active, exp_otf);
            end
            default: begin
                chk("R6 R7 frame count", nf, 1);
                if (exp_otf) begin
                    chk("R6 frame length", len_log[base_frame % 256], 16);
                    chk("R6 frame bits", mosi_log[base_frame % 256], {8'h0, 2'b10, ch, 10'h0});
                end else begin
                    chk("R7 frame length", len_log[base_frame % 256], 24);
                    chk("R7 frame bits", mosi_log[base_frame % 256], 24'h0);
                end
                chk("R8 valid at busy fall", v_idle, 1'b1);
                chk("R8 single valid", vcnt - v0, 1);
                chk("R6 R7 sample", rslt_data, r0[23:12]);
                chk("R10 conv no fault", rslt_fault, 1'b0);
            end
        endcase
    endtask

    initial begin
        int unsigned wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                chk("watchdog", 32'd1, 32'd0);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset busy", busy, 1'b0);
        chk("R1 reset cs_n", cs_n, 1'b1);
        chk("R1 reset sclk", sclk, 1'b0);
        chk("R8 reset valid", rslt_valid, 1'b0);
        chk("R5 reset mode", otf_active, 1'b0);

        // R9: reserved op does nothing
        base_frame = frame_total;
        pulse_start(2'd3, 8'h10, 8'h02, 4'd0);
        chk("R9 reserved busy", busy, 1'b0);
        for (int k = 0; k < 30; k++) @(negedge clk);
        chk("R9 reserved no frame", frame_total - base_frame, 0);
        chk("R9 reserved mode", otf_active, 1'b0);

        // status reads: healthy and faulty patterns (R3, R10)
        do_cmd(2'd1, 8'h00, 8'h00, 4'd0, 24'hFFFFFF, 24'h80A5C3, 1'b0);
        do_cmd(2'd1, 8'h00, 8'h00, 4'd0, 24'h000000, 24'h81FFFF, 1'b0);
        do_cmd(2'd1, 8'h00, 8'h00, 4'd0, 24'h5A5A5A, 24'hFF0000, 1'b0);
        do_cmd(2'd1, 8'h00, 8'h00, 4'd0, 24'hFFFFFF, 24'h00FFFF, 1'b0);

        // R7 manual conversion, then R5 enter on-the-fly, R6 channels 0 and 15
        do_cmd(2'd2, 8'h00, 8'h00, 4'd9, 24'hABC123, 24'h0, 1'b0);
        do_cmd(2'd0, 8'h10, 8'h02, 4'd0, 24'h0, 24'h0, 1'b0);
        do_cmd(2'd2, 8'h00, 8'h00, 4'd0, 24'h123FFF, 24'h0, 1'b0);
        do_cmd(2'd2, 8'h00, 8'h00, 4'd15, 24'hFED000, 24'h0, 1'b0);
        // R5 write elsewhere leaves mode alone
        do_cmd(2'd0, 8'h11, 8'h00, 4'd0, 24'h0, 24'h0, 1'b0);
        // R9 stray start during a read (would toggle the mode if taken)
        do_cmd(2'd1, 8'h22, 8'h00, 4'd0, 24'h0F0F0F, 24'h3C0000, 1'b1);
        // R5 leave on-the-fly mode
        do_cmd(2'd0, 8'h10, 8'h00, 4'd0, 24'h0, 24'h0, 1'b0);
        do_cmd(2'd2, 8'h00, 8'h00, 4'd3, 24'h800800, 24'h0, 1'b0);

        // random mix
        for (int n = 0; n < 50; n++) begin
            logic [1:0] op;
            logic [7:0] a;
            op = 2'($urandom % 3);
            a  = ($urandom % 3 == 0) ? 8'h10 : 8'($urandom);
            do_cmd(op, a, 8'($urandom), 4'($urandom), 24'($urandom), 24'($urandom), 1'b0);
        end

        chk("R1 sclk timing and idle level", sclk_err, 0);
        chk("R4 chip select gap", gap_err, 0);
        chk("R8 valid while busy", vbusy_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule